// File: doc/BRIEF.md
# Tile Video Controller Control-Port Decoder

This block sits behind the 16-bit control port of a tile-based video controller. Every word written to the port is sorted into one of two kinds. It is either a one-word register load into a small register file, or one half of a two-word access command. The block assembles the destination address and access code for the data-port and DMA logic, and it issues a one-cycle DMA start pulse. The pulse is gated by an enable bit held in the register file. A status word is always presented for port reads, and each read also drops any half-finished command.

A two-state machine does the sorting.

States:
- `ST_IDLE`: no command half is outstanding.
- `ST_HALF`: the first command word is held while the block waits for the second.

Transitions:
- `IDLE_REG` (ST_IDLE to ST_IDLE): a write whose top two bits are `10` loads a register.
- `IDLE_FIRST` (ST_IDLE to ST_HALF): any other write is latched as the first half.
- `HALF_SECOND` (ST_HALF to ST_IDLE): any write completes the command, even if its top bits are `10`.
- `HALF_ABORT` (ST_HALF to ST_IDLE): a port read with no write in the same cycle discards the held half.

When a read and a write coincide in ST_HALF, the write takes `HALF_SECOND`.

The DMA engine reads the register file through an index and value pair.

Top module: `tile_ctl_decoder`

## Requirements
- R1: After reset, all registers read zero. No half is pending. `dest_addr`, `acc_code`, `cmd_valid`, `dma_start`, `tgt_vram` and `tgt_cram` are all zero.
- R2: In ST_IDLE, a write with bits 15:14 = `10` loads bits 7:0 into the register indexed by bits 12:8, and bit 13 is ignored. The new value is visible on `reg_val` in the next cycle. An index of NUM_REGS (default 24) or above changes nothing and reads back zero.
- R3: In ST_IDLE, a write whose bits 15:14 are not `10` is held as the first half. Bits 15:14 are the access code and bits 13:0 are address bits 13:0. `dest_addr`, `acc_code` and `cmd_valid` do not change on this write.
- R4: The write that completes a command sets `dest_addr` to {second[1:0], first[13:0]} and `acc_code` to first[15:14]. `cmd_valid` is raised for exactly the one cycle after that write.
- R5: While a half is pending, the next write is always taken as the second half, and no register changes.
- R6: When second-half bit 7 is set and register 1 bit 4 is set, `dma_start` pulses in the same cycle as `cmd_valid`.
- R7: When register 1 bit 4 is clear, second-half bit 7 is ignored and `dma_start` stays low.
- R8: `rd_status` bit 1 follows `dma_busy`, and all other status bits are zero. A read with no write in the same cycle clears a pending half.
- R9: `tgt_vram` is high when `acc_code` is `01`. `tgt_cram` is high when `acc_code` is `11`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control-port write strobe |
| wr_data | input | 16 | Control-port write word |
| rd_en | input | 1 | Control-port read strobe |
| rd_status | output | 16 | Status word |
| dma_busy | input | 1 | Transfer in progress, from the DMA engine |
| reg_sel | input | 5 | Register index for the DMA engine |
| reg_val | output | 8 | Value of the selected register |
| dest_addr | output | 16 | Assembled destination address |
| acc_code | output | 2 | Assembled access code |
| tgt_vram | output | 1 | Access targets video RAM |
| tgt_cram | output | 1 | Access targets colour RAM |
| cmd_valid | output | 1 | One-cycle pulse when a command completes |
| dma_start | output | 1 | One-cycle DMA launch pulse |

## Verification
The bench writes second halves whose top bits look like a register load. A decoder that checked the top bits before the pending state would load register 19 and never finish the command. The bench sends a request with the enable bit clear, to catch a start gate that ignores register 1. It sends a status read between the halves, because a read that left the half pending would turn the next register load into a bogus command to address 0xCFFF. It also writes an out-of-range index and a word with bit 13 set, which show up any address-decoding slip in the register file.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HALF = 1'b1
    } tcd_state_e;

    localparam int WORD_W   = 16;
    localparam int IDX_W    = 5;
    localparam int RDATA_W  = 8;
    localparam logic [1:0] KIND_REG  = 2'b10;
    localparam logic [1:0] CODE_VRAM = 2'b01;
    localparam logic [1:0] CODE_CRAM = 2'b11;
endpackage

// File: rtl/tcd_regfile.sv
module tcd_regfile
    import tcd_pkg::*;
#(
    parameter int NUM_REGS = 24,
    parameter int EN_REG   = 1,
    parameter int EN_BIT   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [RDATA_W-1:0] wr_val,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [RDATA_W-1:0] rd_val,
    output logic               dma_en
);
    localparam int FLAT_W = NUM_REGS * RDATA_W;

    logic [FLAT_W-1:0] flat;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic [RDATA_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                r_q <= '0;
            else if (we && (wr_idx == IDX_W'(i)))
                r_q <= wr_val;
        end
        assign flat[i*RDATA_W +: RDATA_W] = r_q;
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_val = flat[i*RDATA_W +: RDATA_W];
        end
    end

    assign dma_en = flat[EN_REG*RDATA_W + EN_BIT];
endmodule

// File: rtl/tcd_cmd_fsm.sv
module tcd_cmd_fsm
    import tcd_pkg::*;
#(
    parameter int REQ_BIT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic               dma_en,
    output logic               reg_we,
    output logic [IDX_W-1:0]   reg_idx,
    output logic [RDATA_W-1:0] reg_data,
    output logic               cmd_valid,
    output logic               dma_start,
    output logic [WORD_W-1:0]  dest_addr,
    output logic [1:0]         acc_code,
    output logic               pending
);
    localparam int LO_W = WORD_W - 2;

    tcd_state_e     state_q, state_d;
    logic [LO_W-1:0] lo_addr_q;
    logic [1:0]      code_q;
    logic            is_reg_wr;

    assign is_reg_wr = (wr_data[WORD_W-1 -: 2] == KIND_REG);
    assign pending   = (state_q == ST_HALF);

    // Next-state logic: IDLE_REG, IDLE_FIRST, HALF_SECOND, HALF_ABORT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_en && !is_reg_wr) state_d = ST_HALF;
            ST_HALF: if (wr_en || rd_en)      state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign reg_we   = wr_en && is_reg_wr && (state_q == ST_IDLE);
    assign reg_idx  = wr_data[8 +: IDX_W];
    assign reg_data = wr_data[RDATA_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_addr_q <= '0;
            code_q    <= '0;
            dest_addr <= '0;
            acc_code  <= '0;
            cmd_valid <= 1'b0;
            dma_start <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            dma_start <= 1'b0;
            if (state_q == ST_IDLE && wr_en && !is_reg_wr) begin
                lo_addr_q <= wr_data[LO_W-1:0];
                code_q    <= wr_data[WORD_W-1 -: 2];
            end
            if (state_q == ST_HALF && wr_en) begin
                dest_addr <= {wr_data[1:0], lo_addr_q};
                acc_code  <= code_q;
                cmd_valid <= 1'b1;
                dma_start <= wr_data[REQ_BIT] && dma_en;
            end
        end
    end

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R4
    AST_START_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> cmd_valid); // R6
    AST_READ_DROPS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && rd_en && !wr_en) |=> !pending && !cmd_valid); // R8
endmodule

// File: rtl/tile_ctl_decoder.sv
module tile_ctl_decoder
    import tcd_pkg::*;
#(
    parameter int NUM_REGS = 24,
    parameter int EN_REG   = 1,
    parameter int EN_BIT   = 4,
    parameter int REQ_BIT  = 7,
    parameter int BUSY_BIT = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    output logic [15:0] rd_status,
    input  logic        dma_busy,
    input  logic [4:0]  reg_sel,
    output logic [7:0]  reg_val,
    output logic [15:0] dest_addr,
    output logic [1:0]  acc_code,
    output logic        tgt_vram,
    output logic        tgt_cram,
    output logic        cmd_valid,
    output logic        dma_start
);
    logic               reg_we;
    logic [IDX_W-1:0]   reg_idx;
    logic [RDATA_W-1:0] reg_data;
    logic               dma_en;
    logic               pending;

    tcd_cmd_fsm #(.REQ_BIT(REQ_BIT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .dma_en    (dma_en),
        .reg_we    (reg_we),
        .reg_idx   (reg_idx),
        .reg_data  (reg_data),
        .cmd_valid (cmd_valid),
        .dma_start (dma_start),
        .dest_addr (dest_addr),
        .acc_code  (acc_code),
        .pending   (pending)
    );

    tcd_regfile #(.NUM_REGS(NUM_REGS), .EN_REG(EN_REG), .EN_BIT(EN_BIT)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .wr_idx (reg_idx),
        .wr_val (reg_data),
        .rd_idx (reg_sel),
        .rd_val (reg_val),
        .dma_en (dma_en)
    );

    always_comb begin
        rd_status           = '0;
        rd_status[BUSY_BIT] = dma_busy;
    end

    assign tgt_vram = (acc_code == CODE_VRAM);
    assign tgt_cram = (acc_code == CODE_CRAM);

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> dma_en); // R7
    AST_REGS_HOLD_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && wr_en) |=> $stable(dma_en)); // R5
endmodule

// File: tb/tile_ctl_decoder_tb.sv
module tile_ctl_decoder_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_status;
    logic        dma_busy = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [7:0]  reg_val;
    logic [15:0] dest_addr;
    logic [1:0]  acc_code;
    logic        tgt_vram, tgt_cram, cmd_valid, dma_start;

    int applied = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_ctl_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_status(rd_status), .dma_busy(dma_busy),
        .reg_sel(reg_sel), .reg_val(reg_val), .dest_addr(dest_addr),
        .acc_code(acc_code), .tgt_vram(tgt_vram), .tgt_cram(tgt_cram),
        .cmd_valid(cmd_valid), .dma_start(dma_start)
    );

    // op(2: 1=write 2=read) data(16) exp_cmd exp_start exp_dest(16) exp_code(2)
    localparam logic [37:0] VEC [NVEC] = '{
        {2'd1, 16'h8114, 1'b0, 1'b0, 16'h0000, 2'b00}, // R2 reg1=0x14, enable on
        {2'd1, 16'h4123, 1'b0, 1'b0, 16'h0000, 2'b00}, // R3 first half held
        {2'd1, 16'h0082, 1'b1, 1'b1, 16'h8123, 2'b01}, // R4 R6 R9 complete, start
        {2'd1, 16'hC005, 1'b0, 1'b0, 16'h8123, 2'b01}, // R3 first half, colour RAM
        {2'd1, 16'h9301, 1'b1, 1'b0, 16'h4005, 2'b11}, // R5 R9 10xx taken as second
        {2'd1, 16'h8104, 1'b0, 1'b0, 16'h4005, 2'b11}, // R2 reg1=0x04, enable off
        {2'd1, 16'h4000, 1'b0, 1'b0, 16'h4005, 2'b11}, // R3 first half
        {2'd1, 16'h0080, 1'b1, 1'b0, 16'h0000, 2'b01}, // R7 request ignored
        {2'd1, 16'h0FFF, 1'b0, 1'b0, 16'h0000, 2'b01}, // R3 first half
        {2'd2, 16'h0000, 1'b0, 1'b0, 16'h0000, 2'b01}, // R8 read drops half
        {2'd1, 16'h8203, 1'b0, 1'b0, 16'h0000, 2'b01}  // R8 now a register load
    };

    task automatic step(input logic [1:0] op, input logic [15:0] d);
        wr_en   = (op == 2'd1);
        rd_en   = (op == 2'd2);
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic chk_reg(input logic [4:0] idx, input logic [7:0] exp, input string req);
        reg_sel = idx;
        #1;
        applied++;
        if (reg_val !== exp) begin
            miscompares++;
            $display("FAIL %s reg%0d: actual %h expected %h", req, idx, reg_val, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        applied++;
        if ({dest_addr, acc_code, cmd_valid, dma_start, tgt_vram, tgt_cram} !== '0) begin
            miscompares++;
            $display("FAIL R1 outputs: actual %h %b %b %b expected 0",
                     dest_addr, acc_code, cmd_valid, dma_start);
        end
        chk_reg(5'd1, 8'h00, "R1");

        for (int v = 0; v < NVEC; v++) begin
            logic [37:0] e;
            e = VEC[v];
            step(e[37:36], e[35:20]);
            applied++;
            if (cmd_valid !== e[19] || dma_start !== e[18] || dest_addr !== e[17:2]
                || acc_code !== e[1:0] || tgt_vram !== (e[1:0] == 2'b01)
                || tgt_cram !== (e[1:0] == 2'b11)) begin
                miscompares++;
                $display("FAIL R4/R6/R7/R9 vec%0d: actual cmd=%b st=%b dst=%h code=%b v=%b c=%b expected cmd=%b st=%b dst=%h code=%b",
                         v, cmd_valid, dma_start, dest_addr, acc_code, tgt_vram, tgt_cram,
                         e[19], e[18], e[17:2], e[1:0]);
            end
        end

        chk_reg(5'd1, 8'h04, "R2");
        chk_reg(5'd2, 8'h03, "R8");
        chk_reg(5'd19, 8'h00, "R5");
        step(2'd1, 16'h9355);
        chk_reg(5'd19, 8'h55, "R2");
        step(2'd1, 16'h9F77);
        chk_reg(5'd31, 8'h00, "R2");
        chk_reg(5'd23, 8'h00, "R2");
        step(2'd1, 16'hA1AA);
        chk_reg(5'd1, 8'hAA, "R2");

        // R8 status word
        dma_busy = 1'b1;
        rd_en = 1'b1;
        #1;
        applied++;
        if (rd_status !== 16'h0002) begin
            miscompares++;
            $display("FAIL R8 status busy: actual %h expected 0002", rd_status);
        end
        dma_busy = 1'b0;
        #1;
        applied++;
        if (rd_status !== 16'h0000) begin
            miscompares++;
            $display("FAIL R8 status idle: actual %h expected 0000", rd_status);
        end
        rd_en = 1'b0;

        summary();
    end
endmodule